// File: doc/BRIEF.md
# Serially Programmed Glitch-Free Clock Gate

This block stops and restarts twelve clock outputs one by one under the control of a simple two-wire serial link. A free-running serial clock samples a data line on its rising edge. While nothing is being sent, the line rests high. A low sample is a start bit. It is followed by twelve non-return-to-zero enable bits, one per serial clock period. The twelve bits are collected in a shadow register. When the last bit arrives, all twelve are copied into the active enable register in a single step.

Each enable reaches its own clock through a two-stage synchroniser that is clocked on the falling edge of that clock. This means a gate can only open or close while its clock is low, so a gated output never shows a shortened high pulse. A stopped output is held at 0. Two further clock outputs pass straight through and cannot be stopped.

Top module: `ser_clk_gate`

## Requirements
- R1: After reset is asserted (active-low, asynchronous), every enable bit is 1, the receiver is idle, and all gated outputs follow their input clocks.
- R2: While the receiver is idle, a high sample on the data line leaves both the receiver and the enables unchanged. A low sample is taken as a start bit.
- R3: After a start bit, exactly 12 more bits are sampled on successive rising edges of the serial clock. The k-th of them (k = 0..11) becomes `enables[k]` and controls `clk_out[k]`. Indices 0-3 are group A outputs 0-3, indices 4-7 are group B outputs 0-3, indices 8-10 are group C outputs 1-3, and index 11 is the sync output.
- R4: `enables` changes only on the rising edge that samples the 12th bit, and all of its bits change together on that edge. It keeps its previous value throughout the frame.
- R5: When an enable bit is 1, `clk_out[k]` equals `clk_in[k]`. When it is 0, `clk_out[k]` is held at 0. The new value takes effect within three falling edges of `clk_in[k]`.
- R6: Every high pulse on a gated output lasts exactly one full high phase of its input clock. No runt pulse occurs.
- R7: `fixed_clk_out` always equals `fixed_clk_in`, whatever the enables hold.
- R8: A new start bit may follow the 12th bit of a frame on the very next serial clock period.
- R9: If reset is asserted in the middle of a frame, the partial frame is discarded and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line; high when idle |
| clk_in | input | 12 | Clocks that can be stopped |
| fixed_clk_in | input | 2 | Clocks that always run |
| clk_out | output | 12 | Gated clocks |
| fixed_clk_out | output | 2 | Pass-through clocks |
| enables | output | 12 | Active enable register |

## Verification
The bench watches the enable register on every serial clock period of each frame. A design that exposed shifted bits early, or that took one bit too many or too few, would show the wrong value before the commit or a rotated pattern after it. A single-bit pattern pins down the bit order: a reversed shift would stop or run the wrong output. Every gated output's high pulses are timed against its own input's high phase, so gating on the wrong edge or without synchronisation would produce short pulses. Back-to-back frames and a reset in mid-frame expose a receiver that needs an idle gap between frames or that keeps its bit count across reset.

// File: rtl/ser_clk_gate.sv
module ser_clk_gate #(
  parameter int NUM_GATED = 12,
  parameter int NUM_FIXED = 2
) (
  input  logic                 ser_clk,
  input  logic                 rst_n,
  input  logic                 ser_data,
  input  logic [NUM_GATED-1:0] clk_in,
  input  logic [NUM_FIXED-1:0] fixed_clk_in,
  output logic [NUM_GATED-1:0] clk_out,
  output logic [NUM_FIXED-1:0] fixed_clk_out,
  output logic [NUM_GATED-1:0] enables
);
  localparam int CW = $clog2(NUM_GATED);
  localparam logic [CW-1:0] LAST = CW'(NUM_GATED - 1);

  logic                 busy;
  logic [CW-1:0]        cnt;
  logic [NUM_GATED-1:0] shadow;
  logic                 last_bit;

  assign last_bit = busy && (cnt == LAST);

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      shadow  <= '1;
      enables <= '1;
    end else if (!busy) begin
      if (!ser_data) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      shadow[cnt] <= ser_data;
      if (last_bit) begin
        busy    <= 1'b0;
        enables <= {ser_data, shadow[NUM_GATED-2:0]};
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assert_cnt_range_R3: assert property (@(posedge ser_clk) disable iff (!rst_n)
    busy |-> cnt <= LAST);
  assert_idle_hold_R2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && ser_data) |=> (!busy && $stable(enables)));
  assert_start_arms_R2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && !ser_data) |=> (busy && cnt == '0));
  assert_commit_R4: assert property (@(posedge ser_clk) disable iff (!rst_n)
    last_bit |=> (!busy && enables[NUM_GATED-1] == $past(ser_data)));
  assert_no_partial_R4: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && !last_bit) |=> $stable(enables));

  // R5/R6: enable retimed on the falling edge of its own clock
  for (genvar g = 0; g < NUM_GATED; g++) begin : g_gate
    logic s1, s2;
    always_ff @(negedge clk_in[g] or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= enables[g];
        s2 <= s1;
      end
    end
    assign clk_out[g] = clk_in[g] & s2;
  end

  // R7
  assign fixed_clk_out = fixed_clk_in;
endmodule

// File: tb/ser_clk_gate_test.sv
`timescale 1ns/1ps
module ser_clk_gate_test;
  localparam int N = 12;
  logic ser_clk = 1'b0, rst_n = 1'b0, ser_data = 1'b1;
  logic [N-1:0] clk_in = '0;
  logic [1:0] fixed_clk_in = '0;
  logic [N-1:0] clk_out, enables;
  logic [1:0] fixed_clk_out;
  int checks = 0, fails = 0, runts = 0;
  bit mon_on = 1'b0;
  logic [N-1:0] exp_en = '1;

  ser_clk_gate uut (.ser_clk(ser_clk), .rst_n(rst_n), .ser_data(ser_data),
    .clk_in(clk_in), .fixed_clk_in(fixed_clk_in), .clk_out(clk_out),
    .fixed_clk_out(fixed_clk_out), .enables(enables));

  always #2 ser_clk = ~ser_clk;
  always #3 fixed_clk_in[0] = ~fixed_clk_in[0];
  always #7 fixed_clk_in[1] = ~fixed_clk_in[1];

  for (genvar i = 0; i < N; i++) begin : g_clk
    real rise_t = -1.0;
    always #(5 + i) clk_in[i] = ~clk_in[i];
    always @(posedge clk_out[i]) rise_t = $realtime;
    always @(negedge clk_out[i])
      if (mon_on && rise_t >= 0.0 && ($realtime - rise_t) != real'(5 + i)) runts++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    int bad = 0, fixed_bad = 0;
    #80;
    for (int s = 0; s < 120; s++) begin
      #0.5;
      if (clk_out !== (clk_in & exp_en)) bad++;
      if (fixed_clk_out !== fixed_clk_in) fixed_bad++;
      #0.5;
    end
    chk(bad == 0, req, "gated outputs vs inputs&enables", bad, 0);
    chk(fixed_bad == 0, "R7", "fixed outputs follow inputs", fixed_bad, 0);
  endtask

  // drives start + 12 bits; last bit left on the line; checks R4 during frame
  task automatic frame_bits(input logic [N-1:0] v);
    int early = 0;
    @(negedge ser_clk) ser_data = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge ser_clk);
      if (enables !== exp_en) early++;
      ser_data = v[k];
    end
    chk(early == 0, "R4", "enables unchanged inside frame", early, 0);
  endtask

  task automatic send_frame(input logic [N-1:0] v, input string req);
    frame_bits(v);
    @(negedge ser_clk) ser_data = 1'b1;
    exp_en = v;
    chk(enables === v, req, "enables after frame", enables, v);
  endtask

  task automatic t_reset;
    chk(enables === '1, "R1", "enables after reset", enables, 12'hFFF);
    check_outputs("R1");
  endtask

  task automatic t_idle;
    repeat (40) @(negedge ser_clk) ser_data = 1'b1;
    chk(enables === exp_en, "R2", "idle high line leaves enables", enables, exp_en);
  endtask

  task automatic t_all_off;
    send_frame('0, "R3");
    check_outputs("R5");
  endtask

  task automatic t_order;
    send_frame(12'h001, "R3");
    check_outputs("R3");
    send_frame(12'h800, "R3");
    check_outputs("R3");
  endtask

  task automatic t_pattern;
    send_frame(12'hA5C, "R5");
    check_outputs("R5");
    send_frame(12'h3F1, "R6");
    check_outputs("R6");
  endtask

  task automatic t_back_to_back;
    frame_bits(12'h5A5);
    exp_en = 12'h5A5;
    frame_bits(12'h0F3);
    @(negedge ser_clk) ser_data = 1'b1;
    exp_en = 12'h0F3;
    chk(enables === 12'h0F3, "R8", "second of back-to-back frames", enables, 12'h0F3);
    check_outputs("R8");
  endtask

  task automatic t_reset_mid;
    mon_on = 1'b0;
    @(negedge ser_clk) ser_data = 1'b0;
    for (int k = 0; k < 5; k++) @(negedge ser_clk) ser_data = k[0];
    rst_n = 1'b0;
    ser_data = 1'b1;
    repeat (3) @(negedge ser_clk);
    chk(enables === '1, "R9", "enables during reset", enables, 12'hFFF);
    rst_n = 1'b1;
    exp_en = '1;
    #40 mon_on = 1'b1;
    repeat (10) @(negedge ser_clk);
    chk(enables === '1, "R9", "no stray commit after reset", enables, 12'hFFF);
    send_frame(12'h0F0, "R9");
    check_outputs("R9");
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge ser_clk);
    rst_n = 1'b1;
    #40 mon_on = 1'b1;
    @(negedge ser_clk);
    t_reset();
    t_idle();
    t_all_off();
    t_order();
    t_pattern();
    t_idle();
    t_back_to_back();
    t_reset_mid();
    send_frame(12'hFFF, "R5");
    check_outputs("R5");
    chk(runts == 0, "R6", "runt pulses on gated outputs", runts, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule